// File: doc/BRIEF.md
# Line-Phase-Corrected System Clock Divider

This block runs on a master clock at six times the colour subcarrier and derives a system clock at three times the subcarrier by halving it. Because the subcarrier is not an integer multiple of the line rate, the derived clock is given a 180 degree phase jump on every second video line. The jump is made by holding the halving stage for one master cycle, and it keeps the derived clock pseudo-line-locked. Once per field, the block also issues a start pulse for the line delay memories. That pulse is aligned to the first line sync after a field sync, and this field alignment absorbs the slow PAL frame offset.

A bypass select turns all clock processing on or off. In bypass the derived clock and the start pulse are held low and the line parity is cleared. The current mode is driven on a status output. The line-sync and field-sync detect flags arrive asynchronously. Each passes through a two-flop synchronizer, and only its rising edge is used.

The block contains three state machines. The mode machine has the states MODE_BYPASS and MODE_COMB: it moves to MODE_COMB when the registered bypass select is low and back to MODE_BYPASS when it is high. The field machine has the states FLD_IDLE, FLD_LINES and FLD_ARMED. It goes from FLD_IDLE to FLD_LINES on entering comb mode, from FLD_LINES to FLD_ARMED on a field-sync edge, and from FLD_ARMED to FLD_LINES on the next line-sync edge, when it issues the start pulse. Leaving comb mode returns it from any state to FLD_IDLE. The divider machine has the states DIV_OFF, DIV_RUN and DIV_HOLD. It goes from DIV_OFF to DIV_RUN in comb mode, from DIV_RUN to DIV_HOLD on a stall request, from DIV_HOLD back to DIV_RUN after one cycle, and to DIV_OFF from any state on bypass.

Top module: `line_phase_clkdiv`

## Requirements
- R1: In comb mode, once the mode has been active for three master cycles, sys_clk inverts on every master cycle, except that it keeps its level for one cycle during a stall.
- R2: A line-sync rising edge that sets the line parity from 0 to 1 causes exactly one stalled master cycle. An edge that sets the parity from 1 to 0 causes none. The parity is 0 after entering comb mode, so the first line edge stalls.
- R3: A field-sync rising edge changes neither the parity nor the clock. The first line-sync edge after it clears the parity to 0, so that line does not stall and the next one does.
- R4: dl_start is a one-master-cycle pulse that is high on the third master clock edge after the raw line-sync input rises, but only for the first line-sync edge after a field-sync edge. This gives exactly one pulse per field.
- R5: Line-sync edges that follow no pending field-sync edge produce no dl_start pulse.
- R6: Stalls never stack. sys_clk never holds its level for more than two consecutive samples while comb mode is active.
- R7: From the second cycle after bypass is selected, sys_clk and dl_start stay low. Sync edges during bypass have no effect, and the parity is 0 when comb mode returns.
- R8: comb_active is high one master cycle after bypass_sel is sampled low and low one master cycle after it is sampled high (comb = 1).
- R9: A line-sync input that stays high for many cycles counts as a single edge and causes at most one stall.
- R10: While rst_n is low, sys_clk, dl_start and comb_active are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mck | input | 1 | Master clock, six times the subcarrier |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_det | input | 1 | Line sync detect flag, asynchronous |
| vsync_det | input | 1 | Field sync detect flag, asynchronous |
| bypass_sel | input | 1 | 1 selects bypass, 0 selects comb mode |
| sys_clk | output | 1 | Divided system clock with line phase correction |
| dl_start | output | 1 | Delay-line start pulse, once per field |
| comb_active | output | 1 | Current mode status, 1 in comb mode |

## Verification
A wrong line parity shows at the ports as a missing or extra held level of sys_clk within about four master cycles of the offending line edge. Every line therefore gets its stall count checked against the parity computed in the bench. A field machine stuck in the wrong state shows as a dl_start pulse that is missing, duplicated or misplaced on the first line after a field edge, and the bench checks the exact cycle. A parity that survives bypass shows as a missing stall on the first line after comb mode returns.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    typedef enum logic {
        MODE_BYPASS = 1'b0,
        MODE_COMB   = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        FLD_IDLE  = 2'd0,
        FLD_LINES = 2'd1,
        FLD_ARMED = 2'd2
    } fld_e;

    typedef enum logic [1:0] {
        DIV_OFF  = 2'd0,
        DIV_RUN  = 2'd1,
        DIV_HOLD = 2'd2
    } div_e;
endpackage

// File: rtl/lpc_edge_sync.sv
// Multi-stage synchronizer with a rising-edge strobe.
module lpc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], din};
        end
    end

    // The edge is taken between the last synchronizer stage and the delay flop.
    assign rise = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/lpc_mode_fsm.sv
// Bypass/comb mode state machine.
module lpc_mode_fsm
    import lpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bypass_sel,
    output logic comb
);
    mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_BYPASS;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_BYPASS: if (!bypass_sel) state_d = MODE_COMB;
            MODE_COMB:   if (bypass_sel)  state_d = MODE_BYPASS;
            default:     state_d = MODE_BYPASS;
        endcase
    end

    always_comb comb = (state_q == MODE_COMB);
endmodule

// File: rtl/lpc_field_seq.sv
// Line parity tracking, stall requests and the per-field start pulse.
module lpc_field_seq
    import lpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic comb,
    input  logic h_rise,
    input  logic v_rise,
    output logic stall_req,
    output logic dl_start
);
    fld_e state_q, state_d;
    logic par_q, par_d;
    logic stall_q, stall_d;
    logic start_q, start_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLD_IDLE;
            par_q   <= 1'b0;
            stall_q <= 1'b0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            par_q   <= par_d;
            stall_q <= stall_d;
            start_q <= start_d;
        end
    end

    always_comb begin
        state_d = state_q;
        par_d   = par_q;
        stall_d = 1'b0;
        start_d = 1'b0;
        unique case (state_q)
            FLD_IDLE: begin
                par_d = 1'b0;
                if (comb) state_d = FLD_LINES;
            end
            FLD_LINES: begin
                if (!comb) begin
                    state_d = FLD_IDLE;
                    par_d   = 1'b0;
                end else if (v_rise) begin
                    state_d = FLD_ARMED;
                end else if (h_rise) begin
                    par_d   = ~par_q;
                    stall_d = ~par_q;
                end
            end
            FLD_ARMED: begin
                if (!comb) begin
                    state_d = FLD_IDLE;
                    par_d   = 1'b0;
                end else if (h_rise) begin
                    state_d = FLD_LINES;
                    par_d   = 1'b0;
                    start_d = 1'b1;
                end
            end
            default: begin
                state_d = FLD_IDLE;
                par_d   = 1'b0;
            end
        endcase
    end

    always_comb begin
        stall_req = stall_q;
        dl_start  = start_q;
    end
endmodule

// File: rtl/lpc_phase_div.sv
// Divide-by-two with a one-cycle hold for the phase jump.
module lpc_phase_div
    import lpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic comb,
    input  logic stall_req,
    output logic div_clk,
    output logic hold
);
    div_e state_q, state_d;
    logic clk_q, clk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIV_OFF;
            clk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            clk_q   <= clk_d;
        end
    end

    always_comb begin
        state_d = state_q;
        clk_d   = clk_q;
        unique case (state_q)
            DIV_OFF: begin
                clk_d = 1'b0;
                if (comb) state_d = DIV_RUN;
            end
            DIV_RUN: begin
                if (!comb) begin
                    state_d = DIV_OFF;
                    clk_d   = 1'b0;
                end else if (stall_req) begin
                    state_d = DIV_HOLD;
                end else begin
                    clk_d = ~clk_q;
                end
            end
            DIV_HOLD: begin
                // A request seen here is dropped: no second skipped cycle.
                if (!comb) begin
                    state_d = DIV_OFF;
                    clk_d   = 1'b0;
                end else begin
                    state_d = DIV_RUN;
                    clk_d   = ~clk_q;
                end
            end
            default: begin
                state_d = DIV_OFF;
                clk_d   = 1'b0;
            end
        endcase
    end

    always_comb begin
        div_clk = clk_q;
        hold    = (state_q == DIV_HOLD);
    end
endmodule

// File: rtl/line_phase_clkdiv.sv
module line_phase_clkdiv #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_mck,
    input  logic rst_n,
    input  logic hsync_det,
    input  logic vsync_det,
    input  logic bypass_sel,
    output logic sys_clk,
    output logic dl_start,
    output logic comb_active
);
    localparam int N_SYNC = 2;

    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] rise_v;
    logic comb;
    logic stall_req;
    logic div_hold;

    assign raw_in = {vsync_det, hsync_det};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        lpc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk_mck),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .rise (rise_v[g])
        );
    end

    lpc_mode_fsm u_mode (
        .clk       (clk_mck),
        .rst_n     (rst_n),
        .bypass_sel(bypass_sel),
        .comb      (comb)
    );

    lpc_field_seq u_field (
        .clk      (clk_mck),
        .rst_n    (rst_n),
        .comb     (comb),
        .h_rise   (rise_v[0]),
        .v_rise   (rise_v[1]),
        .stall_req(stall_req),
        .dl_start (dl_start)
    );

    lpc_phase_div u_div (
        .clk      (clk_mck),
        .rst_n    (rst_n),
        .comb     (comb),
        .stall_req(stall_req),
        .div_clk  (sys_clk),
        .hold     (div_hold)
    );

    assign comb_active = comb;
endmodule

// File: rtl/lpc_chk.sv
module lpc_chk (
    input logic clk_mck,
    input logic rst_n,
    input logic bypass_sel,
    input logic sys_clk,
    input logic dl_start,
    input logic comb_active,
    input logic div_hold
);
    // R8
    mode_on_chk: assert property (@(posedge clk_mck) disable iff (!rst_n)
        !bypass_sel |=> comb_active);
    // R8
    mode_off_chk: assert property (@(posedge clk_mck) disable iff (!rst_n)
        bypass_sel |=> !comb_active);
    // R7
    bypass_quiet_chk: assert property (@(posedge clk_mck) disable iff (!rst_n)
        (!comb_active && $past(!comb_active)) |-> (!sys_clk && !dl_start));
    // R4
    start_pulse_chk: assert property (@(posedge clk_mck) disable iff (!rst_n)
        dl_start |=> !dl_start);
    // R4
    start_mode_chk: assert property (@(posedge clk_mck) disable iff (!rst_n)
        dl_start |-> comb_active);
    // R6
    hold_single_chk: assert property (@(posedge clk_mck) disable iff (!rst_n)
        div_hold |=> !div_hold);
    // R1
    clk_run_chk: assert property (@(posedge clk_mck) disable iff (!rst_n)
        (comb_active && $past(comb_active) && $past(comb_active, 2) &&
         $past(comb_active, 3) && $stable(sys_clk))
        |-> ($past(sys_clk) != $past(sys_clk, 2)));
endmodule

bind line_phase_clkdiv lpc_chk u_chk (
    .clk_mck    (clk_mck),
    .rst_n      (rst_n),
    .bypass_sel (bypass_sel),
    .sys_clk    (sys_clk),
    .dl_start   (dl_start),
    .comb_active(comb_active),
    .div_hold   (div_hold)
);

// File: tb/sim_line_phase_clkdiv.sv
`timescale 1ns/1ps
module sim_line_phase_clkdiv;
    logic clk_mck = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_det = 1'b0;
    logic vsync_det = 1'b0;
    logic bypass_sel = 1'b1;
    logic sys_clk, dl_start, comb_active;

    int n_tests = 0;
    int n_fail = 0;
    int holds = 0;
    int dl_cnt = 0;
    int comb_run = 0;
    logic prev_clk = 1'b0;
    bit done = 1'b0;

    always #4 clk_mck = ~clk_mck;

    line_phase_clkdiv u0 (
        .clk_mck(clk_mck), .rst_n(rst_n), .hsync_det(hsync_det),
        .vsync_det(vsync_det), .bypass_sel(bypass_sel), .sys_clk(sys_clk),
        .dl_start(dl_start), .comb_active(comb_active)
    );

    // Observe at the falling edge: count held levels and start pulses.
    always @(negedge clk_mck) begin
        if (comb_active && comb_run >= 2 && sys_clk == prev_clk) holds++;
        if (dl_start) dl_cnt++;
        prev_clk = sys_clk;
        comb_run = comb_active ? comb_run + 1 : 0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_mck);
    endtask

    // One line: sync pulse then idle; returns stall and start counts seen.
    task automatic line(input int width, output int h, output int d);
        holds = 0; dl_cnt = 0;
        hsync_det = 1'b1; cyc(width);
        hsync_det = 1'b0; cyc(24);
        h = holds; d = dl_cnt;
    endtask

    task automatic field_edge(output int h);
        holds = 0;
        vsync_det = 1'b1; cyc(3);
        vsync_det = 1'b0; cyc(12);
        h = holds;
    endtask

    initial begin
        int h, d, bad;
        cyc(3);
        // R10 reset values
        chk(sys_clk == 0 && dl_start == 0 && comb_active == 0, "R10", {sys_clk, dl_start, comb_active}, 0);
        rst_n = 1'b1; cyc(3);
        // R8 still bypass
        chk(comb_active == 0, "R8", comb_active, 0);
        bypass_sel = 1'b0; cyc(1);
        // R8 one cycle later
        chk(comb_active == 1, "R8", comb_active, 1);
        cyc(6);
        // R1/R2/R5: free lines alternate starting with a stall, no start pulse
        for (int j = 1; j <= 4; j++) begin
            line(2, h, d);
            chk(h == (j % 2), "R2", h, j % 2);
            chk(d == 0, "R5", d, 0);
        end
        // R9: a long line-sync level is one edge (parity now 0 -> stall)
        line(60, h, d);
        chk(h == 1, "R9", h, 1);
        // Sweep fields with 1..5 lines each
        for (int f = 1; f <= 5; f++) begin
            field_edge(h);
            chk(h == 0, "R3", h, 0);
            // R4 exact timing of the start pulse
            holds = 0; dl_cnt = 0;
            hsync_det = 1'b1;
            @(negedge clk_mck); @(negedge clk_mck);
            chk(dl_start == 0, "R4", dl_start, 0);
            @(negedge clk_mck);
            chk(dl_start == 1, "R4", dl_start, 1);
            hsync_det = 1'b0;
            @(negedge clk_mck);
            chk(dl_start == 0, "R4", dl_start, 0);
            cyc(20);
            chk(holds == 0 && dl_cnt == 1, "R3", holds * 10 + dl_cnt, 1);
            for (int k = 1; k < f; k++) begin
                line(2, h, d);
                chk(h == (k % 2), "R2", h, k % 2);
                chk(d == 0, "R5", d, 0);
            end
        end
        // R1: long run of plain toggling
        holds = 0; cyc(100);
        chk(holds == 0, "R1", holds, 0);
        // Leave parity at 1, then bypass
        line(2, h, d); // after a sweep line count of 4 parity ends 0; this sets 1
        chk(h == 1, "R2", h, 1);
        bypass_sel = 1'b1; cyc(2);
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            if (i == 5) vsync_det = 1'b1;
            if (i == 10) vsync_det = 1'b0;
            if (i == 20) hsync_det = 1'b1;
            if (i == 25) hsync_det = 1'b0;
            @(negedge clk_mck);
            if (sys_clk || dl_start || comb_active) bad++;
        end
        // R7 outputs quiet in bypass
        chk(bad == 0, "R7", bad, 0);
        bypass_sel = 1'b0; cyc(8);
        line(2, h, d);
        // R7 parity cleared: first line after return stalls, no start pulse
        chk(h == 1, "R7", h, 1);
        chk(d == 0, "R7", d, 0);
        // R6: back-to-back edges still give at most one stall each
        holds = 0;
        hsync_det = 1'b1; cyc(1); hsync_det = 1'b0; cyc(1);
        hsync_det = 1'b1; cyc(1); hsync_det = 1'b0; cyc(20);
        chk(holds == 1, "R6", holds, 1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule